// File: doc/BRIEF.md
# Link Training Watchdog with Stall Recovery

This block brings up a serial link and supervises its training. A start pulse first caps the link speed request to generation 1, and one cycle later raises the training enable. From then on the block samples the controller's debug status once per fixed poll interval. The link counts as up when the link-up bit is set and the in-training bit is clear. At that point the block raises a sticky success flag.

While it waits for the link, the block also looks for a stalled speed change. This is the case where the training state machine sits in its receiver-lock recovery state while the receiver reports no valid data. When that happens, the block drives the receiver data-enable and PLL-enable overrides together for a fixed hold time, then releases them. If the link is still not up after a fixed number of polls, the block drops the training enable and raises a sticky failure flag. Time spent in an override pulse counts toward that limit. All durations are parameters counted in clock cycles.

Top module: `link_train_wdog`

## Requirements
- R1: After reset, `train_en_o`, `link_ok_o`, `link_fail_o`, `spd_cap_o` and `rx_ovr_o` are all 0.
- R2: In the cycle after `start_i` is sampled, `spd_cap_o` reads 1 (generation 1) and `train_en_o` is still 0. `train_en_o` rises one cycle later, and never rises unless `spd_cap_o` was 1 in the cycle before.
- R3: Status is sampled every `POLL_CYC` cycles. Poll k is sampled at the edge `1 + k*POLL_CYC` after the start edge, and its result shows on the outputs right after that edge.
- R4: The link counts as up only when `dbg_status_i[4]` is 1 and `dbg_status_i[29]` is 0. A poll that sees this sets `link_ok_o`; any other combination leaves `link_ok_o` at 0.
- R5: A poll that finds no link-up and no override active, with `train_state_i == 6'h0D` and `rx_valid_i == 0`, starts an override. `rx_ovr_o` becomes 2'b11, where bit 1 is receiver data enable and bit 0 is PLL enable.
- R6: An override holds `rx_ovr_o` at 2'b11 for exactly `OVR_CYC` cycles and then returns to 2'b00. The two bits always move together.
- R7: A poll with `rx_valid_i == 1`, or with any training state other than 6'h0D, applies no override.
- R8: If `MAX_POLLS` polls pass without link-up, `link_fail_o` rises right after the last poll edge. In the same cycle `train_en_o` and `rx_ovr_o` drop to 0.
- R9: The poll counter keeps running during an override, so the failure arrives at the same poll count whether or not an override occurred.
- R10: `link_ok_o` and `link_fail_o` stay set until the next `start_i`, are never set together, and are cleared together with any active override in the cycle after `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start (or restart) a bring-up attempt |
| dbg_status_i | input | 32 | Controller debug status word (bit 4 link up, bit 29 in training) |
| train_state_i | input | 6 | Training state machine state |
| rx_valid_i | input | 1 | Receiver reports valid data |
| train_en_o | output | 1 | Training enable |
| spd_cap_o | output | 4 | Maximum speed request; 1 means generation 1, 0 means not yet capped |
| rx_ovr_o | output | 2 | Receiver override: bit 1 data enable, bit 0 PLL enable |
| link_ok_o | output | 1 | Sticky link-up flag |
| link_fail_o | output | 1 | Sticky training-timeout flag |

## Verification
Every result is counted from the edge that samples `start_i`. The speed cap appears after that edge, the training enable one edge later, and poll k lands at edge `1 + k*POLL_CYC`. An override ends exactly `OVR_CYC` edges after the poll that started it. The bench waits on falling edges for these exact counts. It checks each flag or override one cycle before its due edge, expecting it still clear, and again just after that edge, expecting it set. Random trials place the link-up poll and the noise in the other status bits at random; the failure time is checked both with and without an override in the window.

// File: rtl/ltw_pkg.sv
package ltw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LIMIT = 2'd1,
        ST_POLL  = 2'd2,
        ST_DONE  = 2'd3
    } ltw_state_e;

    localparam int STATUS_W = 32;
    localparam int TSTATE_W = 6;
    localparam int SPD_W    = 4;
    localparam logic [SPD_W-1:0] SPD_GEN1 = 4'd1;
endpackage

// File: rtl/ltw_poll_timer.sv
module ltw_poll_timer #(
    parameter int POLL_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(POLL_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (run_i)
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/ltw_ovr_timer.sv
module ltw_ovr_timer #(
    parameter int OVR_CYC = 750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic fire_i,
    output logic active_o
);
    localparam int CW = (OVR_CYC > 1) ? $clog2(OVR_CYC) : 1;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } ovr_t;

    ovr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d = '0;
        end else if (fire_i && !s_q.active) begin
            s_d.active = 1'b1;
            s_d.cnt    = CW'(OVR_CYC - 1);
        end else if (s_q.active) begin
            if (s_q.cnt == '0) s_d.active = 1'b0;
            else               s_d.cnt    = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.active;

    a_r6_fire_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(fire_i));
endmodule

// File: rtl/ltw_status_decode.sv
module ltw_status_decode
    import ltw_pkg::*;
#(
    parameter int UP_BIT    = 4,
    parameter int TRAIN_BIT = 29,
    parameter logic [TSTATE_W-1:0] RECOV_STATE = 6'h0D
) (
    input  logic [STATUS_W-1:0] status_i,
    input  logic [TSTATE_W-1:0] tstate_i,
    input  logic                rx_valid_i,
    output logic                up_o,
    output logic                stuck_o
);
    always_comb begin
        up_o    = status_i[UP_BIT] && !status_i[TRAIN_BIT];
        stuck_o = !rx_valid_i && (tstate_i == RECOV_STATE);
    end
endmodule

// File: rtl/link_train_wdog.sv
module link_train_wdog
    import ltw_pkg::*;
#(
    parameter int POLL_CYC  = 2500,
    parameter int MAX_POLLS = 4000,
    parameter int OVR_CYC   = 750000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [STATUS_W-1:0] dbg_status_i,
    input  logic [TSTATE_W-1:0] train_state_i,
    input  logic                rx_valid_i,
    output logic                train_en_o,
    output logic [SPD_W-1:0]    spd_cap_o,
    output logic [1:0]          rx_ovr_o,
    output logic                link_ok_o,
    output logic                link_fail_o
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] POLL_LIM = PW'(MAX_POLLS);

    typedef struct packed {
        ltw_state_e       st;
        logic [PW-1:0]    polls;
        logic [SPD_W-1:0] spd;
        logic             ok;
        logic             fail;
    } ctl_t;

    ctl_t s_d, s_q;
    logic tick, up, stuck, ovr_act, ovr_fire, ovr_clr;
    logic [PW-1:0] polls_nx;

    ltw_poll_timer #(.POLL_CYC(POLL_CYC)) i_poll (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i),
        .run_i(s_q.st == ST_POLL), .tick_o(tick)
    );

    ltw_status_decode i_dec (
        .status_i(dbg_status_i), .tstate_i(train_state_i),
        .rx_valid_i(rx_valid_i), .up_o(up), .stuck_o(stuck)
    );

    ltw_ovr_timer #(.OVR_CYC(OVR_CYC)) i_ovr (
        .clk(clk), .rst_n(rst_n), .clr_i(ovr_clr),
        .fire_i(ovr_fire), .active_o(ovr_act)
    );

    always_comb begin
        s_d      = s_q;
        ovr_fire = 1'b0;
        ovr_clr  = 1'b0;
        polls_nx = s_q.polls + 1'b1;
        if (start_i) begin
            s_d.st    = ST_LIMIT;
            s_d.polls = '0;
            s_d.ok    = 1'b0;
            s_d.fail  = 1'b0;
            ovr_clr   = 1'b1;
        end else begin
            unique case (s_q.st)
                ST_LIMIT: begin
                    s_d.spd = SPD_GEN1;
                    s_d.st  = ST_POLL;
                end
                ST_POLL: begin
                    if (tick) begin
                        s_d.polls = polls_nx;
                        if (up) begin
                            s_d.ok  = 1'b1;
                            s_d.st  = ST_DONE;
                            ovr_clr = 1'b1;
                        end else if (polls_nx == POLL_LIM) begin
                            s_d.fail = 1'b1;
                            s_d.st   = ST_DONE;
                            ovr_clr  = 1'b1;
                        end else if (stuck) begin
                            ovr_fire = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (start_i) s_d.spd = SPD_GEN1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, polls: '0, spd: '0, ok: 1'b0, fail: 1'b0};
        else        s_q <= s_d;
    end

    assign train_en_o  = (s_q.st == ST_POLL) || (s_q.st == ST_DONE && s_q.ok);
    assign spd_cap_o   = s_q.spd;
    assign rx_ovr_o    = {ovr_act, ovr_act};
    assign link_ok_o   = s_q.ok;
    assign link_fail_o = s_q.fail;

    a_r2_cap_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> $past(spd_cap_o) == SPD_GEN1);
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_ok_o && link_fail_o));
    a_r6_override_paired: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr_o[1] == rx_ovr_o[0]);
    a_r5_override_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr_o[1]) |-> ($past(train_state_i) == 6'h0D && !$past(rx_valid_i)));
    a_r8_fail_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_fail_o) |-> (!train_en_o && rx_ovr_o == 2'b00));
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!link_ok_o && !link_fail_o && rx_ovr_o == 2'b00));
    a_r4_ok_needs_up: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ok_o) |-> ($past(dbg_status_i[4]) && !$past(dbg_status_i[29])));
endmodule

// File: tb/test_link_train_wdog.sv
module test_link_train_wdog;
    localparam int P   = 8;
    localparam int MAX = 20;
    localparam int OVR = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] status = 32'h0;
    logic [5:0]  tstate = 6'h0;
    logic        rx_valid = 1'b1;
    logic        train_en, ok, fail;
    logic [3:0]  spd;
    logic [1:0]  ovr;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    link_train_wdog #(.POLL_CYC(P), .MAX_POLLS(MAX), .OVR_CYC(OVR)) i_link_train_wdog (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbg_status_i(status),
        .train_state_i(tstate), .rx_valid_i(rx_valid), .train_en_o(train_en),
        .spd_cap_o(spd), .rx_ovr_o(ovr), .link_ok_o(ok), .link_fail_o(fail)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] up_word(input logic [31:0] noise);
        return (noise | 32'h10) & ~32'h2000_0000;
    endfunction

    function automatic logic [31:0] down_word(input logic [31:0] noise, input bit sel);
        return sel ? (noise | 32'h2000_0000) : (noise & ~32'h10);
    endfunction

    // Returns at the falling edge after the edge that raised train_en.
    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!ok && !fail && ovr == 2'b00, "R10 cleared", {ok, fail, ovr}, 0);
        chk(spd == 4'd1 && !train_en, "R2 cap first", {spd, train_en}, 2);
        @(negedge clk);
        chk(train_en == 1'b1, "R2 enable next", train_en, 1);
    endtask

    initial begin
        void'($urandom(32'd7071));
        waitn(3);
        chk(!train_en && !ok && !fail && ovr == 0 && spd == 0, "R1 reset",
            {train_en, ok, fail, ovr, spd}, 0);
        rst_n = 1'b1;
        waitn(2);

        // R3 R4: link up at the first poll, exact edge
        status = up_word(32'h0);
        do_start();
        waitn(P - 1);
        chk(!ok, "R3 not before poll", ok, 0);
        waitn(1);
        chk(ok && train_en, "R3 R4 up at poll 1", ok, 1);
        waitn(5);
        chk(ok && !fail, "R10 ok sticky", ok, 1);

        // R4 random trials: link comes up at a random poll
        for (int t = 0; t < 8; t++) begin
            int k;
            k = 1 + int'($urandom % (MAX - 2));
            status = down_word($urandom, $urandom % 2);
            tstate = 6'($urandom % 12);
            do_start();
            waitn((k - 1) * P);
            chk(!ok && !fail, "R4 not up yet", ok, 0);
            status = up_word($urandom);
            waitn(P - 1);
            chk(!ok, "R3 before poll k", ok, 0);
            waitn(1);
            chk(ok, "R4 up at poll k", ok, 1);
        end
        tstate = 6'h0;

        // R5 R6: stuck speed change triggers a timed override
        status = 32'h10 | 32'h2000_0000;
        tstate = 6'h0D; rx_valid = 1'b0;
        do_start();
        waitn(P - 1);
        chk(ovr == 2'b00, "R5 no override before poll", ovr, 0);
        waitn(1);
        chk(ovr == 2'b11, "R5 override set", ovr, 3);
        tstate = 6'h00;
        waitn(OVR - 1);
        chk(ovr == 2'b11, "R6 override held", ovr, 3);
        waitn(1);
        chk(ovr == 2'b00, "R6 override released", ovr, 0);

        // R10: start during an override clears it
        tstate = 6'h0D;
        do_start();
        waitn(P);
        chk(ovr == 2'b11, "R5 override again", ovr, 3);
        do_start();
        chk(ovr == 2'b00, "R10 restart clears override", ovr, 0);

        // R7: receiver valid, or another state, gives no override
        tstate = 6'h0D; rx_valid = 1'b1;
        waitn(P);
        chk(ovr == 2'b00, "R7 rx_valid blocks", ovr, 0);
        tstate = 6'h0C; rx_valid = 1'b0;
        waitn(P);
        chk(ovr == 2'b00, "R7 other state blocks", ovr, 0);
        tstate = 6'h0E;
        waitn(P);
        chk(ovr == 2'b00, "R7 state 0E blocks", ovr, 0);

        // R8: timeout with no override
        status = 32'h0; tstate = 6'h0; rx_valid = 1'b1;
        do_start();
        waitn(MAX * P - 1);
        chk(!fail && train_en, "R8 not failed early", fail, 0);
        waitn(1);
        chk(fail && !train_en && !ok, "R8 fail at limit", fail, 1);
        waitn(4);
        chk(fail, "R10 fail sticky", fail, 1);

        // R9: timeout unchanged with overrides running
        tstate = 6'h0D; rx_valid = 1'b0;
        do_start();
        waitn(P);
        chk(ovr == 2'b11, "R9 override active", ovr, 3);
        waitn((MAX - 1) * P - 1);
        chk(!fail, "R9 not failed early", fail, 0);
        waitn(1);
        chk(fail && ovr == 2'b00 && !train_en, "R9 R8 fail at limit", {fail, ovr}, 4);

        do_start();
        chk(!fail, "R10 restart clears fail", fail, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule